// File: doc/BRIEF.md
# Third-Order Sinc Decimator for a One-Bit Modulator Stream

This block turns the one-bit output of a sigma-delta modulator into 16-bit two's-complement PCM samples. Each accepted input bit is treated as +1 or -1. The bits pass through three cascaded running-sum stages at the input rate. Once per output period, three cascaded first-difference stages run at the decimated rate. The result is a third-order sinc low-pass response. It suppresses the shaped quantization noise above the band and lowers the sample rate in a single step.

The decimation factor is chosen at run time from four settings: 32, 64, 128 or 256 input bits per output word. With a 2.048 Mbit/s modulator stream, which is one eighth of a 16.384 MHz master clock, these settings give output rates of 64, 32, 16 and 8 kHz. The internal word is sized for the largest factor, so direct decimation to the lowest rate keeps every bit of growth. The raw result is shifted according to the chosen factor and then clamped to 16 bits.

Writing a new rate code clears the filter state and restarts the output framing. The first three outputs after the change are withheld, because their windows would still contain the cleared history.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is asserted and after it is released, with no inputs accepted, `pcm_out` is 0 and `pcm_vld` is 0.
- R2: `rate_sel` code c (0, 1, 2, 3) selects a decimation factor M = 32 << c. Exactly one `pcm_vld` pulse is produced for every M accepted bits, and successive pulses are M accepted bits apart.
- R3: An input bit of 1 counts as +1 and a bit of 0 counts as -1. A constant stream of ones gives the clamped value +32767, and a constant stream of zeros gives -32768.
- R4: For a repeating bit pattern whose period p divides M and which holds k ones per period, each settled output equals (2k - p) * 32768 / p, clamped to [-32768, 32767]. This holds at every rate code.
- R5: At rate code 0, after at least 5*32 zeros, a step to ones that starts on an output boundary gives the three outputs -20800, 22848 and 32767. These are the samples of the cubed 32-tap boxcar response.
- R6: A change of `rate_sel` clears all filter state and resets the framing. The first `pcm_vld` after the change comes exactly 4*M accepted bits after it, so three output periods are suppressed.
- R7: `pcm_vld` is a single-cycle pulse in the cycle after the clock edge that accepted the last bit of a period. `pcm_out` changes only together with that pulse and holds its value between pulses.
- R8: While `bit_en` is low, `bit_in` is ignored. It changes neither the output values nor the bit count.
- R9: At rate code 3 (M = 256, raw gain 2^24), the full-scale inputs and a one-in-four pattern give +32767, -32768 and -16384 with no wraparound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | High in the cycles that carry a modulator bit |
| bit_in | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| rate_sel | input | 2 | Decimation code, M = 32 << code |
| pcm_out | output | 16 | Decimated two's-complement sample |
| pcm_vld | output | 1 | One-cycle strobe marking a new `pcm_out` |

## Verification
A corrupted running sum or difference register does not show at once. It appears at the next output strobe and stays visible for up to three output periods, until the difference chain has flushed it. The DC and step values are exact for any pattern whose period divides M, so a single wrong carry, a wrong scaling shift or a missing clamp moves the sample well away from its expected value. Faults in the framing counter or in the warm-up counter appear at the ports as pulses at the wrong bit count: a pulse too early after a rate change, or a gap that is not M. These are visible on the first strobe after the change.

// File: rtl/sinc_dec_pkg.sv
package sinc_dec_pkg;

   // width of the mapped +1/-1 input word
   localparam int unsigned IN_W = 2;

   // running-sum word width: input width plus growth of every stage
   function automatic int acc_width(input int order, input int log2_mmax);
      return IN_W + order * log2_mmax;
   endfunction

   // select-code width for a given number of rate settings
   function automatic int sel_width(input int n_rates);
      return (n_rates <= 2) ? 1 : $clog2(n_rates);
   endfunction

   // per-cycle control produced by the framing logic
   typedef struct packed {
      logic clr;    // wipe all filter state this cycle
      logic take;   // accept the input bit this cycle
      logic fire;   // this bit closes an output period
      logic emit;   // the closing period is past the warm-up
   } frame_ctl_t;

endpackage

// File: rtl/sinc_dec_integ.sv
// Cascade of running sums at the input rate. The stages ripple within one
// cycle, so the sum presented at an output boundary already contains the
// bit that closes the period.
module sinc_dec_integ #(
   parameter int ORDER = 3,
   parameter int ACC_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             take,
   input  logic [ACC_W-1:0] x,
   output logic [ACC_W-1:0] sum_o
);

   logic [ORDER-1:0][ACC_W-1:0] nxt;

   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      logic [ACC_W-1:0] st_q;
      logic [ACC_W-1:0] feed;

      if (g == 0) begin : g_head
         assign feed = x;
      end else begin : g_tail
         assign feed = nxt[g-1];
      end

      // modular two's-complement add; wraparound is harmless because
      // the difference chain recovers the exact window value
      assign nxt[g] = st_q + feed;

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            st_q <= '0;
         end else if (take) begin
            st_q <= nxt[g];
         end
      end
   end

   assign sum_o = nxt[ORDER-1];

endmodule

// File: rtl/sinc_dec_comb.sv
// Cascade of first differences, advanced once per output period.
module sinc_dec_comb #(
   parameter int ORDER = 3,
   parameter int ACC_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             fire,
   input  logic [ACC_W-1:0] din,
   output logic [ACC_W-1:0] dout
);

   logic [ORDER-1:0][ACC_W-1:0] diff;

   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      logic [ACC_W-1:0] dly_q;
      logic [ACC_W-1:0] src;

      if (g == 0) begin : g_head
         assign src = din;
      end else begin : g_tail
         assign src = diff[g-1];
      end

      assign diff[g] = src - dly_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            dly_q <= '0;
         end else if (fire) begin
            dly_q <= src;
         end
      end
   end

   assign dout = diff[ORDER-1];

endmodule

// File: rtl/sinc_dec_rate.sv
// Rate code register, output framing counter and warm-up counter.
module sinc_dec_rate
   import sinc_dec_pkg::*;
#(
   parameter int ORDER     = 3,
   parameter int LOG2_MMIN = 5,
   parameter int NUM_RATES = 4,
   parameter int SEL_W     = 2,
   parameter int CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] rate_sel,
   input  logic             bit_en,
   output logic [SEL_W-1:0] rate_o,
   output frame_ctl_t       ctl
);

   localparam int WARM_W = $clog2(ORDER + 1);

   logic [SEL_W-1:0]  sel_eff;
   logic [SEL_W-1:0]  rate_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  period_m1;
   logic [WARM_W-1:0] warm_q;
   logic              last;

   // codes past the last setting fall back to the slowest rate
   if (NUM_RATES == (1 << SEL_W)) begin : g_full_code
      assign sel_eff = rate_sel;
   end else begin : g_clamp_code
      assign sel_eff = (32'(rate_sel) > 32'(NUM_RATES - 1)) ?
                       SEL_W'(NUM_RATES - 1) : rate_sel;
   end

   always_comb begin
      period_m1 = CNT_W'((32'd1 << (32'(LOG2_MMIN) + 32'(rate_q))) - 32'd1);
      last      = (cnt_q == period_m1);
      ctl.clr   = (sel_eff != rate_q);
      ctl.take  = bit_en && !ctl.clr;
      ctl.fire  = ctl.take && last;
      ctl.emit  = (warm_q == WARM_W'(ORDER));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= '0;
         cnt_q  <= '0;
         warm_q <= '0;
      end else begin
         rate_q <= sel_eff;
         if (ctl.clr) begin
            cnt_q  <= '0;
            warm_q <= '0;
         end else begin
            if (ctl.take) begin
               cnt_q <= last ? '0 : cnt_q + 1'b1;
            end
            if (ctl.fire && !ctl.emit) begin
               warm_q <= warm_q + 1'b1;
            end
         end
      end
   end

   assign rate_o = rate_q;

endmodule

// File: rtl/sinc_dec_scale.sv
// Rate-dependent arithmetic right shift followed by a clamp to OUT_W bits.
module sinc_dec_scale #(
   parameter int ACC_W = 26,
   parameter int OUT_W = 16,
   parameter int SH_W  = 5
) (
   input  logic [ACC_W-1:0] raw,
   input  logic [SH_W-1:0]  shift,
   output logic [OUT_W-1:0] pcm
);

   localparam logic signed [ACC_W-1:0] LIM_HI =
      {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] LIM_LO =
      {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [ACC_W-1:0] shifted;

   always_comb begin
      shifted = $signed(raw) >>> shift;
      if (shifted > LIM_HI) begin
         pcm = LIM_HI[OUT_W-1:0];
      end else if (shifted < LIM_LO) begin
         pcm = LIM_LO[OUT_W-1:0];
      end else begin
         pcm = shifted[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
   import sinc_dec_pkg::*;
#(
   parameter  int ORDER     = 3,
   parameter  int OUT_W     = 16,
   parameter  int LOG2_MMIN = 5,
   parameter  int NUM_RATES = 4,
   localparam int SEL_W     = sel_width(NUM_RATES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             bit_in,
   input  logic [SEL_W-1:0] rate_sel,
   output logic [OUT_W-1:0] pcm_out,
   output logic             pcm_vld
);

   localparam int LOG2_MMAX = LOG2_MMIN + NUM_RATES - 1;
   localparam int ACC_W     = acc_width(ORDER, LOG2_MMAX);
   localparam int CNT_W     = LOG2_MMAX;
   localparam int SH_W      = $clog2(ORDER * LOG2_MMAX + 1);

   // elaboration-time parameter checks
   if (ORDER < 1) begin : g_bad_order
      $error("sinc3_decimator: ORDER must be at least 1");
   end
   if (NUM_RATES < 2) begin : g_bad_rates
      $error("sinc3_decimator: NUM_RATES must be at least 2");
   end
   if (ORDER * LOG2_MMIN < OUT_W - 1) begin : g_bad_scale
      $error("sinc3_decimator: smallest factor gives less gain than the output needs");
   end
   if (ACC_W > 64) begin : g_bad_width
      $error("sinc3_decimator: internal word wider than 64 bits");
   end

   frame_ctl_t       ctl;
   logic [SEL_W-1:0] rate_q;
   logic [ACC_W-1:0] x_word;
   logic [ACC_W-1:0] run_sum;
   logic [ACC_W-1:0] win_val;
   logic [SH_W-1:0]  shift_amt;
   logic [OUT_W-1:0] pcm_next;

   sinc_dec_rate #(
      .ORDER     (ORDER),
      .LOG2_MMIN (LOG2_MMIN),
      .NUM_RATES (NUM_RATES),
      .SEL_W     (SEL_W),
      .CNT_W     (CNT_W)
   ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .bit_en   (bit_en),
      .rate_o   (rate_q),
      .ctl      (ctl)
   );

   // 1 -> +1, 0 -> -1 in ACC_W-bit two's complement
   assign x_word = bit_in ? ACC_W'(1) : '1;

   sinc_dec_integ #(
      .ORDER (ORDER),
      .ACC_W (ACC_W)
   ) u_integ (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctl.clr),
      .take  (ctl.take),
      .x     (x_word),
      .sum_o (run_sum)
   );

   sinc_dec_comb #(
      .ORDER (ORDER),
      .ACC_W (ACC_W)
   ) u_comb (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctl.clr),
      .fire  (ctl.fire),
      .din   (run_sum),
      .dout  (win_val)
   );

   // raw gain is M^ORDER = 2^(ORDER*log2 M); keep the top OUT_W-1 magnitude bits
   assign shift_amt = SH_W'(32'(ORDER) * (32'(LOG2_MMIN) + 32'(rate_q)) - 32'(OUT_W - 1));

   sinc_dec_scale #(
      .ACC_W (ACC_W),
      .OUT_W (OUT_W),
      .SH_W  (SH_W)
   ) u_scale (
      .raw   (win_val),
      .shift (shift_amt),
      .pcm   (pcm_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcm_out <= '0;
         pcm_vld <= 1'b0;
      end else begin
         pcm_vld <= ctl.fire && ctl.emit;
         if (ctl.fire && ctl.emit) begin
            pcm_out <= pcm_next;
         end
      end
   end

endmodule

// File: rtl/sinc_dec_check.sv
module sinc_dec_check #(
   parameter int ORDER     = 3,
   parameter int OUT_W     = 16,
   parameter int LOG2_MMIN = 5,
   parameter int SEL_W     = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_en,
   input logic [SEL_W-1:0] rate_sel,
   input logic [OUT_W-1:0] pcm_out,
   input logic             pcm_vld
);

   logic [SEL_W-1:0] rs_q;
   logic [31:0]      in_cnt;
   logic [31:0]      m_cur;

   assign m_cur = 32'd1 << (32'(LOG2_MMIN) + 32'(rs_q));

   // accepted bits since the last rate change
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_q   <= '0;
         in_cnt <= '0;
      end else begin
         rs_q <= rate_sel;
         if (rate_sel != rs_q) begin
            in_cnt <= '0;
         end else if (bit_en) begin
            in_cnt <= in_cnt + 32'd1;
         end
      end
   end

   assert_vld_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_vld |=> !pcm_vld);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pcm_vld |-> $stable(pcm_out));

   assert_needs_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_vld |-> $past(bit_en));

   assert_quiet_after_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rate_sel) |=> !pcm_vld);

   assert_warmup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_vld |-> (in_cnt >= 32'(ORDER + 1) * m_cur));

   assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_vld |-> ((in_cnt & (m_cur - 32'd1)) == 32'd0));

endmodule

bind sinc3_decimator sinc_dec_check #(
   .ORDER     (ORDER),
   .OUT_W     (OUT_W),
   .LOG2_MMIN (LOG2_MMIN),
   .SEL_W     (SEL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .rate_sel (rate_sel),
   .pcm_out  (pcm_out),
   .pcm_vld  (pcm_vld)
);

// File: tb/sinc3_decimator_test.sv
module sinc3_decimator_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bit_en;
   logic        bit_in;
   logic [1:0]  rate_sel;
   logic [15:0] pcm_out;
   logic        pcm_vld;

   int n_chk = 0;
   int n_bad = 0;
   int acc_cnt;
   int base_cnt;
   int out_n;
   int out_val [64];
   int out_at  [64];
   logic vld_prev = 1'b0;

   always #10 clk = ~clk;

   sinc3_decimator uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .bit_in   (bit_in),
      .rate_sel (rate_sel),
      .pcm_out  (pcm_out),
      .pcm_vld  (pcm_vld)
   );

   // bench-side count of accepted bits
   always @(posedge clk) begin
      if (!rst_n) acc_cnt <= 0;
      else if (bit_en) acc_cnt <= acc_cnt + 1;
   end

   // output capture, sampled between clock edges
   always @(negedge clk) begin
      if (rst_n && pcm_vld) begin
         if (out_n < 64) begin
            out_val[out_n] = int'($signed(pcm_out));
            out_at[out_n]  = acc_cnt - base_cnt;
         end
         out_n = out_n + 1;
         if (vld_prev) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL R7 strobe width actual=2 expected=1");
         end
      end
      vld_prev = rst_n && pcm_vld;
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // move to rate r through a different code so the state is always cleared
   task automatic set_rate(input logic [1:0] r);
      @(negedge clk);
      bit_en   = 1'b0;
      rate_sel = r + 2'd1;
      @(negedge clk);
      rate_sel = r;
      repeat (3) @(negedge clk);
      out_n    = 0;
      base_cnt = acc_cnt;
   endtask

   task automatic stream(input logic [7:0] pat, input int plen, input int nbits,
                         input bit idle);
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         bit_en = 1'b1;
         bit_in = pat[i % plen];
         if (idle && (i % 3 == 0)) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = ~pat[i % plen];
         end
      end
      @(negedge clk);
      bit_en = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   function automatic int dc_expect(input logic [7:0] pat, input int plen);
      int k = 0;
      int v;
      for (int i = 0; i < plen; i++) k = k + int'(pat[i]);
      v = (2 * k - plen) * 32768 / plen;
      if (v > 32767) v = 32767;
      return v;
   endfunction

   // scenario: a periodic pattern at one rate, nout outputs after warm-up
   task automatic run_pattern(input string tag, input logic [1:0] r,
                              input logic [7:0] pat, input int plen,
                              input int nout, input bit idle);
      int m = 32 << r;
      int exp = dc_expect(pat, plen);
      set_rate(r);
      stream(pat, plen, (3 + nout) * m, idle);
      check({tag, " R2 count"}, out_n, nout);
      check({tag, " R6 first strobe"}, out_at[0], 4 * m);
      for (int i = 0; i < nout && i < 64; i++) begin
         check({tag, " value"}, out_val[i], exp);
         if (i > 0) check({tag, " R2 spacing"}, out_at[i] - out_at[i-1], m);
      end
      check({tag, " R7 hold"}, int'($signed(pcm_out)), exp);
   endtask

   task automatic test_reset();
      @(negedge clk);
      check("R1 pcm_out in reset", int'(pcm_out), 0);
      check("R1 pcm_vld in reset", int'(pcm_vld), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 pcm_out after reset", int'(pcm_out), 0);
      check("R1 pcm_vld after reset", int'(pcm_vld), 0);
   endtask

   task automatic test_step();
      set_rate(2'd0);
      stream(8'h00, 1, 5 * 32, 1'b0);
      stream(8'hFF, 1, 3 * 32, 1'b0);
      check("R5 count", out_n, 5);
      check("R5 before step", out_val[1], -32768);
      check("R5 first after step", out_val[2], -20800);
      check("R5 second after step", out_val[3], 22848);
      check("R5 third after step", out_val[4], 32767);
      check("R5 spacing", out_at[4] - out_at[3], 32);
   endtask

   initial begin
      rst_n    = 1'b0;
      bit_en   = 1'b0;
      bit_in   = 1'b0;
      rate_sel = 2'd0;
      out_n    = 0;
      base_cnt = 0;
      test_reset();
      run_pattern("R3 ones rate0",    2'd0, 8'hFF, 1, 2, 1'b0);
      run_pattern("R3 ones rate1",    2'd1, 8'hFF, 1, 2, 1'b0);
      run_pattern("R3 ones rate2",    2'd2, 8'hFF, 1, 2, 1'b0);
      run_pattern("R9 ones rate3",    2'd3, 8'hFF, 1, 2, 1'b0);
      run_pattern("R3 zeros rate0",   2'd0, 8'h00, 1, 2, 1'b0);
      run_pattern("R9 zeros rate3",   2'd3, 8'h00, 1, 2, 1'b0);
      run_pattern("R9 one-in-four",   2'd3, 8'h01, 4, 2, 1'b0);
      run_pattern("R4 three-in-four", 2'd1, 8'h07, 4, 3, 1'b0);
      run_pattern("R4 alternating",   2'd2, 8'h01, 2, 2, 1'b0);
      run_pattern("R4 five-in-eight", 2'd0, 8'hE6, 8, 3, 1'b0);
      run_pattern("R8 idle toggling", 2'd2, 8'h07, 4, 2, 1'b1);
      test_step();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule